// File: doc/BRIEF.md
# Table-driven byte-parallel CRC-32 engine

This block computes the 32-bit cyclic redundancy check with the reflected generator 0xEDB88320 (0x04C11DB7 written msbit-first). Data arrives one byte per handshake, and bit 0 of each byte counts as the first bit on the wire. The running remainder starts at all-ones, and the value presented on the output is its bitwise complement. The lookup table is not stored as constants. It is derived during elaboration by running the bit-serial update rule over every index.

A parameter chooses between two datapaths. The wide one uses a 256-entry table and absorbs a full byte per cycle. The compact one uses a 16-entry table twice per byte, low nibble first. In that mode it takes every second cycle off the input handshake, so it runs at one byte per two cycles.

A receiver can pass a message followed by its transmitted CRC through the engine, with the CRC bytes least significant first. A flag then reports whether the frame reached the fixed residue that the post-inversion produces.

Top module: `crc32_table_unit`

## Requirements
- R1: After reset, crc_o reads 0x00000000 (the complement of the all-ones preset), crc_valid_o and check_ok_o are 0, and in_ready_o is 1.
- R2: A frame with the ASCII bytes "123456789" (0x31 to 0x39, start on the first byte, last on the ninth) gives crc_o = 0xCBF43926 while crc_valid_o is 1.
- R3: A byte accepted with in_start_i = 1 discards any previously accumulated remainder and is folded into the all-ones preset instead.
- R4: A single byte carrying both in_start_i and in_last_i forms a complete frame, and its result equals the complemented CRC of that byte alone.
- R5: In a cycle where no byte is accepted and no second-half nibble step is pending, crc_o holds its value. Idle cycles inside a frame do not change the frame's result.
- R6: When the message is followed by its own CRC in least-significant-byte-first order, crc_valid_o comes with check_ok_o = 1 and crc_o = 0x2144DF1C. If any byte is altered, check_ok_o stays 0. check_ok_o is never 1 unless crc_valid_o is 1.
- R7: With NIBBLE = 1, in_ready_o goes to 0 in the cycle after each accepted byte and returns to 1 in the cycle after that. Input offered while in_ready_o is 0 is ignored, including its start and last flags, and both modes give the same CRC for the same frame.
- R8: crc_valid_o is a one-cycle pulse. It comes one cycle after the last byte is accepted in byte mode, and two cycles after in nibble mode.
- R9: With NIBBLE = 0, in_ready_o is constantly 1, and a byte is accepted in every cycle where in_valid_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Byte on in_data_i is offered |
| in_start_i | input | 1 | Offered byte is the first of a frame |
| in_last_i | input | 1 | Offered byte is the last of a frame |
| in_data_i | input | 8 | Data byte, bit 0 processed first |
| in_ready_o | output | 1 | Engine can take a byte this cycle |
| crc_o | output | 32 | Complemented running remainder |
| crc_valid_o | output | 1 | Pulse: crc_o holds a finished frame result |
| check_ok_o | output | 1 | With crc_valid_o: frame reached the good residue |

## Verification
In nibble mode, the second-half update of an accepted byte falls in the same cycle as a new byte being offered. The bench fills every stall cycle with a junk byte that carries start and last. It then judges the case by whether the final CRC and the valid pulse match those of the clean frame, and by whether in_ready_o was low in that cycle. The bench also makes a restart with start fall on a byte that follows a partly accumulated frame, and judges it against a reference computed over the new frame alone.

// File: rtl/crc32_pkg.sv
package crc32_pkg;
  localparam int unsigned CRC_W = 32;
  localparam logic [CRC_W-1:0] POLY_REFL = 32'hEDB88320;
  localparam logic [CRC_W-1:0] PRESET    = 32'hFFFF_FFFF;
  localparam logic [CRC_W-1:0] RESIDUE   = 32'hDEBB_20E3;

  // bit-serial reflected update applied 'steps' times to a table index
  function automatic logic [CRC_W-1:0] lut_entry(input int unsigned idx,
                                                  input int unsigned steps);
    logic [CRC_W-1:0] r;
    r = CRC_W'(idx);
    for (int unsigned k = 0; k < steps; k++) begin
      r = r[0] ? ((r >> 1) ^ POLY_REFL) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/crc32_lut.sv
module crc32_lut #(
  parameter int unsigned IDX_W = 8,
  localparam int unsigned ENTRIES = 1 << IDX_W
) (
  input  logic [IDX_W-1:0]            idx_i,
  output logic [crc32_pkg::CRC_W-1:0] entry_o
);
  logic [crc32_pkg::CRC_W-1:0] table_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    assign table_q[g] = crc32_pkg::lut_entry(g, IDX_W);
  end

  assign entry_o = table_q[idx_i];
endmodule

// File: rtl/crc32_step.sv
module crc32_step #(
  parameter int unsigned CHUNK_W = 8
) (
  input  logic [crc32_pkg::CRC_W-1:0] crc_i,
  input  logic [CHUNK_W-1:0]          data_i,
  output logic [crc32_pkg::CRC_W-1:0] crc_o
);
  logic [CHUNK_W-1:0]          idx;
  logic [crc32_pkg::CRC_W-1:0] entry;

  assign idx = crc_i[CHUNK_W-1:0] ^ data_i;

  crc32_lut #(.IDX_W(CHUNK_W)) u_lut (
    .idx_i  (idx),
    .entry_o(entry)
  );

  assign crc_o = (crc_i >> CHUNK_W) ^ entry;
endmodule

// File: rtl/crc32_table_unit.sv
module crc32_table_unit #(
  parameter bit NIBBLE = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        in_valid_i,
  input  logic        in_start_i,
  input  logic        in_last_i,
  input  logic [7:0]  in_data_i,
  output logic        in_ready_o,
  output logic [31:0] crc_o,
  output logic        crc_valid_o,
  output logic        check_ok_o
);
  import crc32_pkg::*;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NIB_W  = BYTE_W / 2;

  logic [CRC_W-1:0] crc_q, crc_d, base;
  logic             done_d, done_q;

  // start restarts from preset regardless of accumulated state
  assign base = in_start_i ? PRESET : crc_q;

  if (!NIBBLE) begin : g_byte
    logic [CRC_W-1:0] step_out;

    crc32_step #(.CHUNK_W(BYTE_W)) u_step (
      .crc_i (base),
      .data_i(in_data_i),
      .crc_o (step_out)
    );

    assign in_ready_o = 1'b1;
    assign crc_d      = in_valid_i ? step_out : crc_q;
    assign done_d     = in_valid_i & in_last_i;
  end else begin : g_nibble
    logic             phase_q, last_q, accept;
    logic [NIB_W-1:0] hi_q;
    logic [CRC_W-1:0] step_in, step_out;
    logic [NIB_W-1:0] nib_in;

    assign in_ready_o = ~phase_q;
    assign accept     = in_valid_i & ~phase_q;
    assign step_in    = phase_q ? crc_q : base;
    assign nib_in     = phase_q ? hi_q : in_data_i[NIB_W-1:0];

    crc32_step #(.CHUNK_W(NIB_W)) u_step (
      .crc_i (step_in),
      .data_i(nib_in),
      .crc_o (step_out)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        phase_q <= 1'b0;
        last_q  <= 1'b0;
        hi_q    <= '0;
      end else if (accept) begin
        phase_q <= 1'b1;
        last_q  <= in_last_i;
        hi_q    <= in_data_i[BYTE_W-1:NIB_W];
      end else begin
        phase_q <= 1'b0;
      end
    end

    assign crc_d  = (accept | phase_q) ? step_out : crc_q;
    assign done_d = phase_q & last_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q  <= PRESET;
      done_q <= 1'b0;
    end else begin
      crc_q  <= crc_d;
      done_q <= done_d;
    end
  end

  assign crc_o       = ~crc_q;
  assign crc_valid_o = done_q;
  assign check_ok_o  = done_q & (crc_q == RESIDUE);
endmodule

// File: rtl/crc32_table_unit_chk.sv
module crc32_table_unit_chk #(
  parameter bit NIBBLE = 1'b0
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic        in_last_i,
  input logic        in_ready_o,
  input logic [31:0] crc_o,
  input logic        crc_valid_o,
  input logic        check_ok_o
);
  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ready_o && !in_valid_i) |=> $stable(crc_o));

  assert_ok_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    check_ok_o |-> (crc_valid_o && crc_o == 32'h2144DF1C));

  if (!NIBBLE) begin : g_byte
    assert_always_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_ready_o);
    assert_done_lat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i && in_last_i) |=> crc_valid_o);
  end else begin : g_nibble
    assert_stall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i && in_ready_o) |=> !in_ready_o);
    assert_resume_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !in_ready_o |=> in_ready_o);
    assert_done_lat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i && in_ready_o && in_last_i) |=> ##1 crc_valid_o);
  end
endmodule

bind crc32_table_unit crc32_table_unit_chk #(.NIBBLE(NIBBLE)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_last_i  (in_last_i),
  .in_ready_o (in_ready_o),
  .crc_o      (crc_o),
  .crc_valid_o(crc_valid_o),
  .check_ok_o (check_ok_o)
);

// File: tb/crc32_table_unit_test.sv
module crc32_table_unit_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  MAX_CYC    = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // byte-mode DUT (uut) and nibble-mode DUT (uut_nib)
  logic        b_valid = 0, b_start = 0, b_last = 0;
  logic [7:0]  b_data = 0;
  logic        b_ready, b_cvalid, b_ok;
  logic [31:0] b_crc;
  logic        n_valid = 0, n_start = 0, n_last = 0;
  logic [7:0]  n_data = 0;
  logic        n_ready, n_cvalid, n_ok;
  logic [31:0] n_crc;

  crc32_table_unit #(.NIBBLE(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(b_valid), .in_start_i(b_start),
    .in_last_i(b_last), .in_data_i(b_data), .in_ready_o(b_ready),
    .crc_o(b_crc), .crc_valid_o(b_cvalid), .check_ok_o(b_ok));

  crc32_table_unit #(.NIBBLE(1'b1)) uut_nib (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(n_valid), .in_start_i(n_start),
    .in_last_i(n_last), .in_data_i(n_data), .in_ready_o(n_ready),
    .crc_o(n_crc), .crc_valid_o(n_cvalid), .check_ok_o(n_ok));

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] frame [0:15];
  bit nib_stall_ok;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // bitwise reference: reflected, preset all-ones, complemented result
  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      r = r ^ {24'h0, frame[i]};
      for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    end
    return ~r;
  endfunction

  // drives frame[0..n-1]; returns at the negedge where the result pulse is visible
  task automatic send_frame(input bit nib, input int n, input bit gaps);
    nib_stall_ok = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (nib) begin
        n_valid = 1; n_start = (i == 0); n_last = (i == n - 1); n_data = frame[i];
        @(negedge clk);
        #1;
        if (n_ready) nib_stall_ok = 0;
        n_valid = 1; n_start = 1; n_last = 1; n_data = 8'h5A; // junk while stalled
      end else begin
        b_valid = 1; b_start = (i == 0); b_last = (i == n - 1); b_data = frame[i];
        if (gaps && i != n - 1) begin
          @(negedge clk);
          b_valid = 0; b_data = 8'hC3; b_start = 1; b_last = 1;
          @(negedge clk);
          b_valid = 0;
        end
      end
    end
    @(negedge clk);
    b_valid = 0; b_start = 0; b_last = 0;
    n_valid = 0; n_start = 0; n_last = 0;
    #1;
  endtask

  task automatic load_digits();
    for (int i = 0; i < 9; i++) frame[i] = 8'h31 + 8'(i);
  endtask

  task automatic t_reset();
    chk(b_crc == 0 && n_crc == 0, "R1 crc_o after reset", b_crc, 0);
    chk(!b_cvalid && !n_cvalid && !b_ok && !n_ok, "R1 flags after reset",
        {b_cvalid, n_cvalid, b_ok, n_ok}, 0);
    chk(b_ready && n_ready, "R1 ready after reset", {b_ready, n_ready}, 2'b11);
  endtask

  task automatic t_digits_byte();
    load_digits();
    send_frame(0, 9, 0);
    chk(b_cvalid, "R8 byte-mode valid one cycle after last", b_cvalid, 1);
    chk(b_crc == 32'hCBF43926, "R2 check string", b_crc, 32'hCBF43926);
    chk(b_crc == ref_crc(9), "R2 against reference", b_crc, ref_crc(9));
    @(negedge clk); #1;
    chk(!b_cvalid, "R8 valid is a single pulse", b_cvalid, 0);
  endtask

  task automatic t_digits_nibble();
    load_digits();
    send_frame(1, 9, 0);
    chk(nib_stall_ok, "R7 ready low after each accepted byte", nib_stall_ok, 1);
    chk(n_cvalid, "R8 nibble-mode valid two cycles after last", n_cvalid, 1);
    chk(n_crc == 32'hCBF43926, "R7 nibble result with junk in stalls", n_crc,
        32'hCBF43926);
    #1;
    chk(n_ready, "R7 ready back high", n_ready, 1);
    @(negedge clk); #1;
    chk(!n_cvalid, "R8 nibble valid single pulse", n_cvalid, 0);
  endtask

  task automatic t_single();
    frame[0] = 8'h00;
    send_frame(0, 1, 0);
    chk(b_cvalid && b_crc == ref_crc(1), "R4 single byte frame byte mode", b_crc,
        ref_crc(1));
    frame[0] = 8'hFF;
    send_frame(1, 1, 0);
    chk(n_cvalid && n_crc == ref_crc(1), "R4 single byte frame nibble mode", n_crc,
        ref_crc(1));
  endtask

  task automatic t_gaps();
    logic [31:0] held;
    for (int i = 0; i < 6; i++) frame[i] = 8'h10 * 8'(i) + 8'h07;
    send_frame(0, 6, 1);
    chk(b_cvalid && b_crc == ref_crc(6), "R5 idle cycles inside frame", b_crc,
        ref_crc(6));
    // partial frame, then idle: value must hold at partial reference
    frame[0] = 8'hAB; frame[1] = 8'hCD;
    @(negedge clk); b_valid = 1; b_start = 1; b_last = 0; b_data = 8'hAB;
    @(negedge clk); b_start = 0; b_data = 8'hCD;
    @(negedge clk); b_valid = 0; #1;
    held = b_crc;
    chk(held == ref_crc(2), "R5 partial value", held, ref_crc(2));
    repeat (4) @(negedge clk);
    #1;
    chk(b_crc == held && !b_cvalid, "R5 value held while idle", b_crc, held);
  endtask

  task automatic t_restart();
    // leftover partial state from t_gaps; new frame with start must ignore it
    for (int i = 0; i < 4; i++) frame[i] = 8'hE0 + 8'(i);
    send_frame(0, 4, 0);
    chk(b_crc == ref_crc(4), "R3 start discards prior state byte mode", b_crc,
        ref_crc(4));
    @(negedge clk); n_valid = 1; n_start = 1; n_last = 0; n_data = 8'h99;
    @(negedge clk); n_valid = 0;
    send_frame(1, 4, 0);
    chk(n_crc == ref_crc(4), "R3 start discards prior state nibble mode", n_crc,
        ref_crc(4));
  endtask

  task automatic t_residue();
    load_digits();
    frame[9] = 8'h26; frame[10] = 8'h39; frame[11] = 8'hF4; frame[12] = 8'hCB;
    send_frame(0, 13, 0);
    chk(b_ok && b_cvalid, "R6 check ok byte mode", b_ok, 1);
    chk(b_crc == 32'h2144DF1C, "R6 residue byte mode", b_crc, 32'h2144DF1C);
    send_frame(1, 13, 0);
    chk(n_ok && n_crc == 32'h2144DF1C, "R6 residue nibble mode", n_crc,
        32'h2144DF1C);
    frame[4] = 8'h00;
    send_frame(0, 13, 0);
    chk(b_cvalid && !b_ok, "R6 corrupted frame rejected byte mode", b_ok, 0);
    send_frame(1, 13, 0);
    chk(n_cvalid && !n_ok, "R6 corrupted frame rejected nibble mode", n_ok, 0);
  endtask

  task automatic t_back_to_back();
    // consecutive single-byte frames in byte mode, every cycle accepted
    @(negedge clk); b_valid = 1; b_start = 1; b_last = 1; b_data = 8'h31;
    @(negedge clk); #1;
    chk(b_ready && b_cvalid, "R9 byte mode accepts every cycle", b_ready, 1);
    b_data = 8'h32;
    @(negedge clk); b_valid = 0; b_start = 0; b_last = 0; #1;
    frame[0] = 8'h32;
    chk(b_cvalid && b_crc == ref_crc(1), "R9 second back-to-back frame", b_crc,
        ref_crc(1));
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", MAX_CYC, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1;
    t_digits_byte();
    t_digits_nibble();
    t_single();
    t_gaps();
    t_restart();
    t_residue();
    t_back_to_back();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule